// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide programming port of an eight-line interrupt controller. Software writes to two addresses. Address 0 takes the start-of-setup word and the two kinds of operation command. Address 1 takes the remaining setup words and, once setup is complete, the mask. From these writes the block holds the controller's mode bits, the vector base, the mask, the in-service vector and the rotating priority offset. End-of-interrupt commands clear in-service bits. Some of these commands also move the lowest-priority position.

An external resolver, which is not part of this block, reports the winning line on `win_valid` / `win_line`. It uses the `isr`, `imr`, `prio_offset` and mode outputs to pick that line. An acknowledge comes either from a CPU acknowledge cycle (`cpu_ack`) or from a read while poll is armed. The acknowledge is passed to the request latch as `ack_stb` / `ack_line` in the same cycle, and it updates the in-service vector at the next clock edge. Read data is combinational during `rd_en`. All state changes take effect at the rising clock edge.

The setup sequence has four states:
- IDLE: normal operation.
- WAIT_BASE: waiting for the vector base.
- WAIT_CASC: waiting for the cascade word.
- WAIT_MODE: waiting for the mode word.

The transitions between them are:
- start (any state to WAIT_BASE, on a start word).
- base_done (WAIT_BASE to WAIT_CASC, WAIT_MODE or IDLE).
- casc_done (WAIT_CASC to WAIT_MODE or IDLE).
- mode_done (WAIT_MODE to IDLE).

Top module: `pic_cmd_port`

## Requirements
- R1: After reset, mask, in-service vector and priority offset are 0, the setup state is IDLE, and auto-EOI, nested mode, special mask, poll and rotate-on-auto-EOI are off.
- R2: An address-0 write with bit 4 = 1 clears mask, in-service vector, offset, vector base, poll, read select, special mask, auto-EOI, nested mode and rotate-on-auto-EOI. It records "mode word needed" from bit 0 and single mode from bit 1, and moves to WAIT_BASE (start).
- R3: In WAIT_BASE, an address-1 write sets the vector base to bits 7:3. The next state is WAIT_CASC when single mode is off, WAIT_MODE when single mode is on and a mode word is needed, and IDLE otherwise.
- R4: In WAIT_CASC, an address-1 write has no effect on the mode bits and moves to WAIT_MODE if a mode word is needed, else to IDLE. In WAIT_MODE, an address-1 write sets nested mode from bit 4 and auto-EOI from bit 1, then moves to IDLE.
- R5: An address-1 write loads the mask only in IDLE. In the other setup states it leaves the mask unchanged.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 does three things. Bit 2 = 1 arms poll. When bit 1 = 1, bit 0 becomes the read select (1 = in-service, 0 = request); when bit 1 = 0, the read select is kept. When bit 6 = 1, bit 5 becomes special mask mode; when bit 6 = 0, special mask mode is kept.
- R7: An address-0 write with bits 4 and 3 both 0 decodes bits 7:5 as a command. Codes 0 and 4 set rotate-on-auto-EOI to bit 7.
- R8: Code 1 clears the in-service bit of highest priority, where priority starts at line `prio_offset` and wraps upward modulo 8. Code 5 does the same and also sets the offset to that line + 1 (mod 8). Both leave all state unchanged when the in-service vector is 0.
- R9: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and also sets the offset to that line + 1 (mod 8). Code 2 changes nothing.
- R10: Code 6 sets the offset to bits 2:0 + 1 (mod 8).
- R11: An acknowledge is a CPU acknowledge or poll read while `win_valid` = 1. It drives `ack_stb` with `ack_line` = `win_line` in the same cycle. With auto-EOI off it sets that in-service bit. With auto-EOI on it sets no bit, and if rotate-on-auto-EOI is on it sets the offset to the line + 1 (mod 8).
- R12: A read while poll is armed returns 0x80 OR the winning line, or 0x00 with no acknowledge when `win_valid` = 0. Either way it disarms poll.
- R13: A read without poll armed returns the mask at address 1. At address 0 it returns the in-service vector when the read select is 1, and `req_vec` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during rd_en |
| req_vec | input | 8 | Request register from the request latch |
| win_valid | input | 1 | Resolver reports a winning line |
| win_line | input | 3 | Winning line index |
| cpu_ack | input | 1 | CPU interrupt acknowledge cycle |
| ack_stb | output | 1 | Acknowledge to the request latch |
| ack_line | output | 3 | Line being acknowledged |
| isr | output | 8 | In-service vector |
| imr | output | 8 | Mask register |
| prio_offset | output | 3 | Line holding highest priority |
| vec_base | output | 5 | Vector base (upper five bits) |
| auto_eoi | output | 1 | Auto-EOI mode |
| nested_mode | output | 1 | Special fully nested mode |
| special_mask | output | 1 | Special mask mode |

## Verification
A wrong setup state shows up at the very next address-1 write. A mask write that should land is lost, or a setup word lands in the mask, and a mask read one cycle later exposes it. A wrong priority offset or in-service vector makes the next non-specific EOI clear the wrong bit, which appears on `isr` one edge after the command. A poll flag left armed turns the following ordinary read into an acknowledge, so `rdata` and `ack_stb` differ within that read's cycle.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int LINES  = 8;
    localparam int LW     = $clog2(LINES);
    localparam int BASE_W = 8 - LW;

    typedef enum logic [1:0] {
        INIT_IDLE,
        INIT_BASE,
        INIT_CASC,
        INIT_MODE
    } init_st_t;

    // Highest-priority set bit of v, priority starting at line off.
    // Returns {found, line}.
    function automatic logic [LW:0] top_prio(input logic [LINES-1:0] v,
                                             input logic [LW-1:0] off);
        logic [LW:0]   res;
        logic [LW-1:0] idx;
        res = '0;
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = off + LW'(p);
            if (v[idx]) res = {1'b1, idx};
        end
        return res;
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_stb,
    input  logic              need_mode,
    input  logic              single,
    input  logic              data_wr,
    input  logic [BASE_W-1:0] base_in,
    input  logic              nested_in,
    input  logic              aeoi_in,
    output init_st_t          state,
    output logic [BASE_W-1:0] vec_base,
    output logic              nested_mode,
    output logic              auto_eoi
);

    init_st_t state_n;
    logic     need_mode_q, single_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= INIT_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (start_stb) begin
            state_n = INIT_BASE;
        end else if (data_wr) begin
            unique case (state)
                INIT_IDLE: state_n = INIT_IDLE;
                INIT_BASE: state_n = !single_q ? INIT_CASC :
                                     (need_mode_q ? INIT_MODE : INIT_IDLE);
                INIT_CASC: state_n = need_mode_q ? INIT_MODE : INIT_IDLE;
                INIT_MODE: state_n = INIT_IDLE;
                default:   state_n = INIT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_mode_q <= 1'b0;
            single_q    <= 1'b0;
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
        end else if (start_stb) begin
            need_mode_q <= need_mode;
            single_q    <= single;
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
        end else if (data_wr) begin
            if (state == INIT_BASE) vec_base <= base_in;
            if (state == INIT_MODE) begin
                nested_mode <= nested_in;
                auto_eoi    <= aeoi_in;
            end
        end
    end

endmodule

// File: rtl/pic_isr_unit.sv
module pic_isr_unit
    import pic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             cmd_stb,
    input  logic [2:0]       cmd,
    input  logic [LW-1:0]    cmd_line,
    input  logic             ack,
    input  logic [LW-1:0]    ack_line,
    input  logic             auto_eoi,
    input  logic             rot_aeoi,
    output logic [LINES-1:0] isr,
    output logic [LW-1:0]    offset
);

    logic [LINES-1:0] isr_n;
    logic [LW-1:0]    off_n;
    logic [LW:0]      top;

    assign top = top_prio(isr, offset);

    always_comb begin
        isr_n = isr;
        off_n = offset;
        if (cmd_stb) begin
            unique case (cmd)
                3'd1: if (top[LW]) isr_n[top[LW-1:0]] = 1'b0;
                3'd5: if (top[LW]) begin
                    isr_n[top[LW-1:0]] = 1'b0;
                    off_n = top[LW-1:0] + 1'b1;
                end
                3'd3: isr_n[cmd_line] = 1'b0;
                3'd6: off_n = cmd_line + 1'b1;
                3'd7: begin
                    isr_n[cmd_line] = 1'b0;
                    off_n = cmd_line + 1'b1;
                end
                default: ;
            endcase
        end
        if (ack) begin
            if (auto_eoi) begin
                if (rot_aeoi) off_n = ack_line + 1'b1;
            end else begin
                isr_n[ack_line] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr    <= '0;
            offset <= '0;
        end else if (clr_all) begin
            isr    <= '0;
            offset <= '0;
        end else begin
            isr    <= isr_n;
            offset <= off_n;
        end
    end

endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [LINES-1:0]  req_vec,
    input  logic              win_valid,
    input  logic [LW-1:0]     win_line,
    input  logic              cpu_ack,
    output logic              ack_stb,
    output logic [LW-1:0]     ack_line,
    output logic [LINES-1:0]  isr,
    output logic [LINES-1:0]  imr,
    output logic [LW-1:0]     prio_offset,
    output logic [BASE_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic              nested_mode,
    output logic              special_mask
);

    init_st_t init_st;
    logic     wr_cmd, start_wr, ctl_wr, op_wr, data_wr, poll_rd;
    logic     poll_armed, rd_sel_isr, rot_aeoi;

    assign wr_cmd   = wr_en && !addr;
    assign start_wr = wr_cmd && wdata[4];
    assign ctl_wr   = wr_cmd && !wdata[4] && wdata[3];
    assign op_wr    = wr_cmd && !wdata[4] && !wdata[3];
    assign data_wr  = wr_en && addr;
    assign poll_rd  = rd_en && poll_armed;
    assign ack_stb  = (cpu_ack || poll_rd) && win_valid;
    assign ack_line = win_line;

    pic_init_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_stb  (start_wr),
        .need_mode  (wdata[0]),
        .single     (wdata[1]),
        .data_wr    (data_wr),
        .base_in    (wdata[7:LW]),
        .nested_in  (wdata[4]),
        .aeoi_in    (wdata[1]),
        .state      (init_st),
        .vec_base   (vec_base),
        .nested_mode(nested_mode),
        .auto_eoi   (auto_eoi)
    );

    pic_isr_unit u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (start_wr),
        .cmd_stb (op_wr),
        .cmd     (wdata[7:5]),
        .cmd_line(wdata[LW-1:0]),
        .ack     (ack_stb),
        .ack_line(win_line),
        .auto_eoi(auto_eoi),
        .rot_aeoi(rot_aeoi),
        .isr     (isr),
        .offset  (prio_offset)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr          <= '0;
            poll_armed   <= 1'b0;
            rd_sel_isr   <= 1'b0;
            special_mask <= 1'b0;
            rot_aeoi     <= 1'b0;
        end else if (start_wr) begin
            imr          <= '0;
            poll_armed   <= 1'b0;
            rd_sel_isr   <= 1'b0;
            special_mask <= 1'b0;
            rot_aeoi     <= 1'b0;
        end else begin
            if (poll_rd) poll_armed <= 1'b0;
            if (data_wr && init_st == INIT_IDLE) imr <= wdata;
            if (ctl_wr) begin
                if (wdata[2]) poll_armed   <= 1'b1;
                if (wdata[1]) rd_sel_isr   <= wdata[0];
                if (wdata[6]) special_mask <= wdata[5];
            end
            if (op_wr && wdata[6:5] == 2'b00) rot_aeoi <= wdata[7];
        end
    end

    always_comb begin
        if (poll_rd)
            rdata = win_valid ? {1'b1, {(7-LW){1'b0}}, win_line} : 8'h00;
        else if (addr)
            rdata = imr;
        else
            rdata = rd_sel_isr ? isr : req_vec;
    end

endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk
    import pic_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             addr,
    input logic [7:0]       wdata,
    input logic             win_valid,
    input logic             ack_stb,
    input logic [LW-1:0]    ack_line,
    input logic [LINES-1:0] isr,
    input logic [LINES-1:0] imr,
    input logic [LW-1:0]    prio_offset,
    input logic             auto_eoi,
    input logic             poll_armed,
    input init_st_t         init_st
);

    // R2
    start_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !addr && wdata[4] |=> init_st == INIT_BASE && imr == '0 && isr == '0);

    // R4
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr && init_st == INIT_MODE |=> init_st == INIT_IDLE);

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr && init_st == INIT_IDLE |=> imr == $past(wdata));

    // R10
    offset_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !addr && wdata[7:3] == 5'b11000 && !ack_stb
        |=> prio_offset == $past(wdata[LW-1:0]) + 1'b1);

    // R11
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb && !auto_eoi && !wr_en |=> isr[$past(ack_line)]);

    // R12
    ack_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |-> win_valid);

    // R12
    poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && poll_armed && !wr_en |=> !poll_armed);

endmodule

bind pic_cmd_port pic_cmd_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .win_valid  (win_valid),
    .ack_stb    (ack_stb),
    .ack_line   (ack_line),
    .isr        (isr),
    .imr        (imr),
    .prio_offset(prio_offset),
    .auto_eoi   (auto_eoi),
    .poll_armed (poll_armed),
    .init_st    (init_st)
);

// File: tb/tb_pic_cmd_port.sv
module tb_pic_cmd_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] req_vec = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic       cpu_ack = 1'b0;
    logic       ack_stb;
    logic [2:0] ack_line;
    logic [7:0] isr, imr;
    logic [2:0] prio_offset;
    logic [4:0] vec_base;
    logic       auto_eoi, nested_mode, special_mask;

    int vectors = 0;
    int fails   = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    pic_cmd_port dut (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 0; rd_en = 0; cpu_ack = 0; win_valid = 0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        idle();
    endtask

    // driver: push expected {ack, rdata}, then drive the read
    task automatic rd(input logic a, input logic [7:0] exp, input logic exp_ack, input string tag);
        exp_q.push_back({exp_ack, exp});
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1; addr = a;
        idle();
    endtask

    task automatic ack(input logic [2:0] line);
        @(negedge clk);
        cpu_ack = 1; win_valid = 1; win_line = line;
        idle();
    endtask

    // monitor: compare each read against the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_en) begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " rdata"}, rdata, e[7:0]);
                check({t, " ack"}, {7'd0, ack_stb}, {7'd0, e[8]});
            end
        end
    end

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 isr", isr, 8'h00);
        check("R1 offset", {5'd0, prio_offset}, 8'h00);
        check("R1 modes", {5'd0, auto_eoi, nested_mode, special_mask}, 8'h00);
        rd(1, 8'h00, 0, "R1 mask");
        wr(1, 8'h3C);
        rd(1, 8'h3C, 0, "R5 idle mask");
        // R2 start word clears mask
        wr(0, 8'h11);
        rd(1, 8'h00, 0, "R2 mask cleared");
        wr(1, 8'h48);
        check("R3 base", {3'd0, vec_base}, 8'h09);
        rd(1, 8'h00, 0, "R5 base not mask");
        wr(1, 8'hFF);   // cascade word
        check("R4 casc ignored", {6'd0, auto_eoi, nested_mode}, 8'h00);
        wr(1, 8'h01);   // mode word
        wr(1, 8'hA5);
        rd(1, 8'hA5, 0, "R4 back to idle");
        // R3 single, no mode word
        wr(0, 8'h12);
        wr(1, 8'h20);
        wr(1, 8'h77);
        rd(1, 8'h77, 0, "R3 single no mode word");
        // R4 single with mode word
        wr(0, 8'h13);
        wr(1, 8'h08);
        wr(1, 8'h12);
        check("R4 mode bits", {6'd0, auto_eoi, nested_mode}, 8'h03);
        wr(1, 8'h0F);
        rd(1, 8'h0F, 0, "R4 idle after mode");
        // normal setup, no auto-EOI
        wr(0, 8'h11); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00);
        ack(3); ack(5); ack(6);
        check("R11 isr set", isr, 8'h68);
        // R13 / R6 read select
        wr(0, 8'h0B);
        rd(0, 8'h68, 0, "R13 isr read");
        req_vec = 8'h91;
        wr(0, 8'h0A);
        rd(0, 8'h91, 0, "R13 req read");
        wr(0, 8'h09);
        rd(0, 8'h91, 0, "R6 select kept");
        rd(1, 8'h00, 0, "R13 mask read");
        // R8 non-specific EOI
        wr(0, 8'h20);
        check("R8 eoi", isr, 8'h60);
        wr(0, 8'hC4);
        check("R10 set offset", {5'd0, prio_offset}, 8'h05);
        wr(0, 8'hA0);
        check("R8 rot eoi isr", isr, 8'h40);
        check("R8 rot eoi off", {5'd0, prio_offset}, 8'h06);
        // R9 specific
        wr(0, 8'h66);
        check("R9 specific", isr, 8'h00);
        ack(2);
        wr(0, 8'hE2);
        check("R9 rot specific isr", isr, 8'h00);
        check("R9 rot specific off", {5'd0, prio_offset}, 8'h03);
        ack(1);
        wr(0, 8'h41);
        check("R9 code 2 nop", isr, 8'h02);
        wr(0, 8'h61);
        wr(0, 8'h20);
        check("R8 empty isr", {isr[4:0], prio_offset}, 8'h03);
        // R12 poll
        wr(0, 8'h0C);
        exp_q.push_back({1'b1, 8'h84});
        tag_q.push_back("R12 poll hit");
        @(negedge clk); rd_en = 1; addr = 0; win_valid = 1; win_line = 3'd4;
        idle();
        check("R11 poll ack isr", isr, 8'h10);
        rd(1, 8'h00, 0, "R12 poll disarmed");
        wr(0, 8'h0C);
        rd(0, 8'h00, 0, "R12 poll miss");
        check("R12 miss no ack", isr, 8'h10);
        // R7 / R11 auto-EOI
        wr(0, 8'h11); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h02);
        wr(0, 8'h80);
        ack(2);
        check("R7 aeoi rot isr", isr, 8'h00);
        check("R7 aeoi rot off", {5'd0, prio_offset}, 8'h03);
        wr(0, 8'h00);
        ack(5);
        check("R11 aeoi no rot", {isr[4:0], prio_offset}, 8'h03);
        // R6 special mask
        wr(0, 8'h68);
        check("R6 smm on", {7'd0, special_mask}, 8'h01);
        wr(0, 8'h28);
        check("R6 smm kept", {7'd0, special_mask}, 8'h01);
        wr(0, 8'h48);
        check("R6 smm off", {7'd0, special_mask}, 8'h00);
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule